// File: doc/BRIEF.md
# Comparator-Driven Set/Reset Latch Peripheral

This block holds a single set/reset state bit that two comparator results and software can both drive. Comparator 1, when its enable bit is on, sets the state. Comparator 2, when its enable bit is on, clears it. Software can also force a set or a clear by writing a self-clearing trigger bit in the 8-bit control register. That register sits on a simple synchronous bus with a one-bit address. Address 0 selects the control register. Address 1 is a read-only status word that always carries the synchronized comparator results.

Each comparator has an output pin with its own select bit. The select bit routes either the synchronized comparator result or the latch state to that pin. One more control bit is plain storage, brought out as an enable for an external reference. The comparator inputs pass through a synchronizer with a parameterized depth of two stages before any logic uses them. The latch is a flop on the system clock.

Top module: `srl_periph`

## Requirements
- R1: After reset, the control register reads 0x00, the status word reads 0x00, and `latchQ`, `pin1Out`, `pin2Out` and `refEnable` are all 0.
- R2: A write to address 0 stores bits 7, 6, 5, 4 and 0. A read of address 0 returns them in those positions. Bits 3, 2 and 1 always read as 0.
- R3: While bit 5 (set enable) is 1, comparator 1 at 1 sets `latchQ` on the third rising edge after the input changes. While bit 5 is 0, comparator 1 leaves `latchQ` unchanged.
- R4: While bit 4 (reset enable) is 1, comparator 2 at 1 clears `latchQ` on the third rising edge after the input changes. While bit 4 is 0, comparator 2 leaves `latchQ` unchanged.
- R5: A write to address 0 with bit 3 at 1 sets `latchQ` on that same write edge. The trigger lasts for that one cycle only.
- R6: A write to address 0 with bit 2 at 1 clears `latchQ` on that same write edge. The trigger lasts for that one cycle only.
- R7: When a set source and a reset source are active in the same cycle, from comparators, triggers or both, `latchQ` is cleared.
- R8: `pin1Out` equals `latchQ` when bit 6 is 1. It equals synchronized comparator 1 when bit 6 is 0.
- R9: `pin2Out` equals `latchQ` when bit 7 is 1. It equals synchronized comparator 2 when bit 7 is 0.
- R10: A read of address 1 returns synchronized comparator 1 in bit 0 and comparator 2 in bit 1, with bits 7..2 at 0. The value follows a comparator input after two rising edges, whatever the latch or select state.
- R11: `refEnable` equals the stored bit 0 and has no effect on `latchQ`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 1 | 0 selects control register, 1 selects status |
| busWr | input | 1 | Write strobe, sampled on the rising edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the addressed word (combinational) |
| cmp1Raw | input | 1 | Asynchronous comparator 1 result |
| cmp2Raw | input | 1 | Asynchronous comparator 2 result |
| pin1Out | output | 1 | Comparator 1 pin drive |
| pin2Out | output | 1 | Comparator 2 pin drive |
| latchQ | output | 1 | Latch state |
| refEnable | output | 1 | Reference enable storage bit |

## Verification
Read data is combinational, so the bench checks it 1 ns after changing the address, with no edge in between. A software trigger takes effect on the write edge itself, so `latchQ` is checked just after that edge. A comparator change reaches the status word and the raw pin path after two rising edges, and reaches `latchQ` after three. The bench changes comparator inputs just after an edge and checks at those counts. For R3 it also checks one edge early, to confirm the latch has not moved before its due cycle.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int REG_W = 8;
  localparam int NUM_CMP = 2;
  localparam int SYNC_STAGES = 2;

  localparam int BIT_PIN2SEL = 7;
  localparam int BIT_PIN1SEL = 6;
  localparam int BIT_SETEN = 5;
  localparam int BIT_RSTEN = 4;
  localparam int BIT_PULSESET = 3;
  localparam int BIT_PULSERST = 2;
  localparam int BIT_REFEN = 0;

  typedef struct packed {
    logic [NUM_CMP-1:0] pinSel;
    logic setEn;
    logic rstEn;
    logic setPulse;
    logic rstPulse;
  } latchStrobe_t;
endpackage

// File: rtl/srl_ctrl.sv
module srl_ctrl
  import srl_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busAddr,
  input  logic                busWr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [NUM_CMP-1:0]  cmpStatus,
  output latchStrobe_t        strobe,
  output logic                refEn,
  output logic [DATA_W-1:0]   busRdata
);
  logic [NUM_CMP-1:0] pinSelQ;
  logic setEnQ;
  logic rstEnQ;
  logic refEnQ;
  logic ctrlWr;

  assign ctrlWr = busWr && !busAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinSelQ <= '0;
      setEnQ  <= 1'b0;
      rstEnQ  <= 1'b0;
      refEnQ  <= 1'b0;
    end else if (ctrlWr) begin
      pinSelQ <= {busWdata[BIT_PIN2SEL], busWdata[BIT_PIN1SEL]};
      setEnQ  <= busWdata[BIT_SETEN];
      rstEnQ  <= busWdata[BIT_RSTEN];
      refEnQ  <= busWdata[BIT_REFEN];
    end
  end

  always_comb begin
    strobe.pinSel   = pinSelQ;
    strobe.setEn    = setEnQ;
    strobe.rstEn    = rstEnQ;
    strobe.setPulse = ctrlWr && busWdata[BIT_PULSESET];
    strobe.rstPulse = ctrlWr && busWdata[BIT_PULSERST];
  end

  assign refEn = refEnQ;

  always_comb begin
    busRdata = '0;
    if (busAddr) begin
      busRdata[NUM_CMP-1:0] = cmpStatus;
    end else begin
      busRdata[BIT_PIN2SEL] = pinSelQ[1];
      busRdata[BIT_PIN1SEL] = pinSelQ[0];
      busRdata[BIT_SETEN]   = setEnQ;
      busRdata[BIT_RSTEN]   = rstEnQ;
      busRdata[BIT_REFEN]   = refEnQ;
    end
  end
endmodule

// File: rtl/srl_datapath.sv
module srl_datapath
  import srl_pkg::*;
#(
  parameter int STAGES = SYNC_STAGES
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CMP-1:0] cmpRaw,
  input  latchStrobe_t       strobe,
  output logic [NUM_CMP-1:0] cmpSync,
  output logic               latchQ,
  output logic [NUM_CMP-1:0] pinOut
);
  logic setHit;
  logic rstHit;
  logic stateQ;

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_sync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], cmpRaw[c]};
    end
    assign cmpSync[c] = chain[STAGES-1];
  end

  assign setHit = (cmpSync[0] && strobe.setEn) || strobe.setPulse;
  assign rstHit = (cmpSync[1] && strobe.rstEn) || strobe.rstPulse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       stateQ <= 1'b0;
    else if (rstHit) stateQ <= 1'b0;
    else if (setHit) stateQ <= 1'b1;
  end

  assign latchQ = stateQ;

  for (genvar p = 0; p < NUM_CMP; p++) begin : g_pin
    assign pinOut[p] = strobe.pinSel[p] ? stateQ : cmpSync[p];
  end
endmodule

// File: rtl/srl_periph.sv
module srl_periph
  import srl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busAddr,
  input  logic             busWr,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  input  logic             cmp1Raw,
  input  logic             cmp2Raw,
  output logic             pin1Out,
  output logic             pin2Out,
  output logic             latchQ,
  output logic             refEnable
);
  latchStrobe_t strobe;
  logic [NUM_CMP-1:0] cmpSync;
  logic [NUM_CMP-1:0] pinOut;

  srl_ctrl #(.DATA_W(REG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .cmpStatus(cmpSync), .strobe(strobe),
    .refEn(refEnable), .busRdata(busRdata)
  );

  srl_datapath #(.STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .cmpRaw({cmp2Raw, cmp1Raw}), .strobe(strobe),
    .cmpSync(cmpSync), .latchQ(latchQ), .pinOut(pinOut)
  );

  assign pin1Out = pinOut[0];
  assign pin2Out = pinOut[1];
endmodule

// File: rtl/srl_periph_chk.sv
module srl_periph_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busAddr,
  input logic       busWr,
  input logic [7:0] busWdata,
  input logic [7:0] busRdata,
  input logic       pin1Out,
  input logic       pin2Out,
  input logic       latchQ,
  input logic       refEnable
);
  p_ctrl_zero_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busAddr |-> busRdata[3:1] == 3'b000);

  p_status_upper_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    busAddr |-> busRdata[7:2] == 6'b0);

  p_pulse_rst_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busAddr && busWdata[2]) |=> !latchQ);

  p_pin1_latch_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busAddr && busRdata[6]) |-> pin1Out == latchQ);

  p_pin2_latch_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busAddr && busRdata[7]) |-> pin2Out == latchQ);

  p_ref_store_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busAddr) |=> refEnable == $past(busWdata[0]));
endmodule

bind srl_periph srl_periph_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
  .busWdata(busWdata), .busRdata(busRdata), .pin1Out(pin1Out),
  .pin2Out(pin2Out), .latchQ(latchQ), .refEnable(refEnable)
);

// File: tb/srl_periph_bench.sv
`timescale 1ns/1ps
module srl_periph_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busAddr = 1'b0;
  logic busWr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic cmp1Raw = 1'b0;
  logic cmp2Raw = 1'b0;
  logic pin1Out, pin2Out, latchQ, refEnable;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  srl_periph u_srl_periph (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .cmp1Raw(cmp1Raw),
    .cmp2Raw(cmp2Raw), .pin1Out(pin1Out), .pin2Out(pin2Out),
    .latchQ(latchQ), .refEnable(refEnable)
  );

  // {write data, expected readback, expected latchQ after write}
  localparam logic [16:0] TABLE [7] = '{
    {8'hFF, 8'hF1, 1'b0},
    {8'h48, 8'h40, 1'b1},
    {8'h51, 8'h51, 1'b1},
    {8'hA5, 8'hA1, 1'b0},
    {8'h0C, 8'h00, 1'b0},
    {8'h88, 8'h80, 1'b1},
    {8'h00, 8'h00, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wrCtrl(input logic [7:0] d);
    @(negedge clk);
    busAddr = 1'b0; busWr = 1'b1; busWdata = d;
    @(posedge clk); #1;
    busWr = 1'b0; busWdata = 8'h00;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    busAddr = a; #1; d = busRdata;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=hang expected=done");
    finish();
  end

  initial begin
    logic [7:0] r;
    #9 rstN = 1'b1;
    edges(1);
    // R1 reset state
    rd(1'b0, r); check("R1 ctrl", r, 8'h00);
    rd(1'b1, r); check("R1 status", r, 8'h00);
    check("R1 outs", {4'h0, latchQ, pin1Out, pin2Out, refEnable}, 8'h00);

    // R2/R5/R6/R7 table walk
    for (int i = 0; i < 7; i++) begin
      wrCtrl(TABLE[i][16:9]);
      rd(1'b0, r); check("R2 readback", r, TABLE[i][8:1]);
      check("R5/R6/R7 latch after write", {7'h0, latchQ}, {7'h0, TABLE[i][0]});
    end

    // R3 set enable
    wrCtrl(8'h04);
    cmp1Raw = 1'b1; edges(3);
    check("R3 disabled no set", {7'h0, latchQ}, 8'h00);
    rd(1'b1, r); check("R10 status c1", r, 8'h01);
    cmp1Raw = 1'b0; edges(3);
    wrCtrl(8'h20);
    cmp1Raw = 1'b1; edges(2);
    check("R3 not early", {7'h0, latchQ}, 8'h00);
    edges(1);
    check("R3 set", {7'h0, latchQ}, 8'h01);
    cmp1Raw = 1'b0; edges(3);

    // R4 reset enable
    cmp2Raw = 1'b1; edges(3);
    check("R4 disabled no reset", {7'h0, latchQ}, 8'h01);
    rd(1'b1, r); check("R10 status c2", r, 8'h02);
    cmp2Raw = 1'b0; edges(3);
    wrCtrl(8'h30);
    cmp2Raw = 1'b1; edges(3);
    check("R4 reset", {7'h0, latchQ}, 8'h00);
    cmp2Raw = 1'b0; edges(3);

    // R7 comparators both high
    wrCtrl(8'h08);
    check("R5 pulse set", {7'h0, latchQ}, 8'h01);
    wrCtrl(8'h30);
    cmp1Raw = 1'b1; cmp2Raw = 1'b1; edges(4);
    check("R7 reset wins", {7'h0, latchQ}, 8'h00);
    cmp2Raw = 1'b0; edges(3);
    check("R3 set after reset drops", {7'h0, latchQ}, 8'h01);

    // R8/R9 pin selects, R10 independence
    wrCtrl(8'h40);
    cmp1Raw = 1'b0; cmp2Raw = 1'b1; edges(3);
    check("R8 pin1 latch", {7'h0, pin1Out}, 8'h01);
    check("R9 pin2 raw", {7'h0, pin2Out}, 8'h01);
    rd(1'b1, r); check("R10 status with select", r, 8'h02);
    wrCtrl(8'h80);
    check("R8 pin1 raw", {7'h0, pin1Out}, 8'h00);
    cmp2Raw = 1'b0; edges(2);
    check("R9 pin2 latch", {7'h0, pin2Out}, 8'h01);
    wrCtrl(8'h84);
    check("R9 pin2 follows clear", {7'h0, pin2Out}, 8'h00);
    check("R6 pulse reset", {7'h0, latchQ}, 8'h00);

    // R11 reference enable
    wrCtrl(8'h01);
    check("R11 ref on", {7'h0, refEnable}, 8'h01);
    check("R11 latch untouched", {7'h0, latchQ}, 8'h00);
    wrCtrl(8'h08);
    wrCtrl(8'h00);
    check("R11 ref off", {7'h0, refEnable}, 8'h00);
    check("R11 latch kept", {7'h0, latchQ}, 8'h01);
    finish();
  end
endmodule